// File: doc/BRIEF.md
# Signed Command PWM Mapper with Dead Band

This block turns a signed two's complement motor command into drive for the two sides of an H-bridge. Positive commands pulse the forward line and negative commands pulse the reverse line. The pulse width grows in proportion to how far the command's magnitude lies past a dead band around zero. Inside that dead band both lines stay low and a flag is raised. The half-width of the dead band is a parameter, so one design serves a channel with a narrow band and one with a wide band.

A coarse mode serves a low-resolution channel. In that mode only the top eight bits of the command count, and the low four bits are read as zero. The PWM counter then advances once every `SLOW_DIV` clocks, which gives a longer period. The command and mode are sampled only when a PWM period starts, so a mid-period write never cuts a pulse short. Dropping the enable parks both lines low at once and holds the counter at zero.

Top module: `signed_deadband_pwm`

## Requirements
- R1: `code` is two's complement. When the sign bit (bit 11) is 0, only `drive_pos` may pulse; when it is 1, only `drive_neg` may pulse. The other line stays low for the whole period, and the two lines are never high together.
- R2: A period lasts PER = 2047 − DEADBAND counter steps. For a magnitude M > DEADBAND, the active line is high for the first min(M − DEADBAND, PER) steps of the period and low for the rest.
- R3: A magnitude M ≤ DEADBAND (both signs, bounds inclusive) keeps both lines low for the whole period and holds `in_band` high.
- R4: Code 0x7FF and code 0x800 each drive their line high for the entire period (100 % duty). The larger magnitude of 0x800 saturates.
- R5: With `coarse_mode` = 1, the command is taken as bits [11:4] with bits [3:0] forced to zero. The counter advances once every SLOW_DIV clocks, so the period is PER × SLOW_DIV clocks.
- R6: `code` and `coarse_mode` are sampled only on the clock edge that ends the last step of a period. Any change within a period has no effect until the next period begins.
- R7: While `en` is 0, both lines are low in the same cycle, the counter is held at zero, and the command is resampled on every clock. The first period after `en` rises starts from count zero.
- R8: `in_band` reports the dead-band status of the command that is in effect for the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| en | input | 1 | Enable; low forces both lines low and clears the counter |
| coarse_mode | input | 1 | 1 selects the 8-bit command with the slow counter |
| code | input | CODE_W | Signed command, two's complement |
| drive_pos | output | 1 | Forward bridge side PWM |
| drive_neg | output | 1 | Reverse bridge side PWM |
| in_band | output | 1 | Command in effect lies inside the dead band |

## Verification
The bench builds the block with a dead-band half-width of 0x52 and SLOW_DIV of 2. A period is then 1965 steps, which is short enough to run many full periods in the cycle budget. The wide band lets one command, 0x05F, land outside the band in full mode but inside it in coarse mode, so the low-nibble truncation shows up directly at the outputs. A behavioural model runs alongside the design and is compared on every clock. This comparison covers mid-period code changes, disabling during a pulse, and mode switches at a period boundary. Per-period pulse counts also check the duty at both dead-band edges and at both full-scale codes.

// File: rtl/signed_deadband_pwm.sv
module signed_deadband_pwm #(
  parameter int CODE_W      = 12,
  parameter int DEADBAND    = 31,
  parameter int SLOW_DIV    = 4,
  parameter int COARSE_BITS = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              coarse_mode,
  input  logic [CODE_W-1:0] code,
  output logic              drive_pos,
  output logic              drive_neg,
  output logic              in_band
);
  localparam int FULL = 2 ** (CODE_W - 1) - 1;
  localparam int PER  = FULL - DEADBAND;
  localparam int DROP = CODE_W - COARSE_BITS;
  localparam int PW   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CODE_W-1:0] DB_V  = CODE_W'(DEADBAND);
  localparam logic [CODE_W-1:0] PER_V = CODE_W'(PER);
  localparam logic [PW-1:0]     PRE_LAST = PW'(SLOW_DIV - 1);

  logic [CODE_W-1:0] eff, mag, excess, duty_n;
  logic              sgn, band_n;

  assign eff    = coarse_mode ? {code[CODE_W-1:DROP], {DROP{1'b0}}} : code;
  assign sgn    = eff[CODE_W-1];
  assign mag    = sgn ? (~eff + 1'b1) : eff;
  assign band_n = (mag <= DB_V);
  assign excess = mag - DB_V;
  assign duty_n = band_n ? '0 : ((excess > PER_V) ? PER_V : excess);

  logic [CODE_W-1:0] cnt, duty_q;
  logic [PW-1:0]     pre;
  logic              neg_q, band_q, slow_q;
  logic              tick, wrap;

  assign tick = !slow_q || (pre == PRE_LAST);
  assign wrap = tick && (cnt == PER_V - 1'b1);

  always_ff @(posedge clk) begin
    if (!en) begin
      cnt    <= '0;
      pre    <= '0;
      duty_q <= duty_n;
      neg_q  <= sgn;
      band_q <= band_n;
      slow_q <= coarse_mode;
    end else begin
      if (slow_q) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      else        pre <= '0;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        duty_q <= duty_n;
        neg_q  <= sgn;
        band_q <= band_n;
        slow_q <= coarse_mode;
      end
    end
  end

  assign drive_pos = en && !neg_q && (cnt < duty_q);
  assign drive_neg = en &&  neg_q && (cnt < duty_q);
  assign in_band   = band_q;

  p_one_side_r1: assert property (@(posedge clk) disable iff (!en)
    !(drive_pos && drive_neg));

  p_band_quiet_r3: assert property (@(posedge clk) disable iff (!en)
    in_band |-> (!drive_pos && !drive_neg));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!en)
    cnt < PER_V);

  p_pos_starts_period_r6: assert property (@(posedge clk) disable iff (!en)
    $rose(drive_pos) |-> (cnt == '0));

  p_neg_starts_period_r6: assert property (@(posedge clk) disable iff (!en)
    $rose(drive_neg) |-> (cnt == '0));
endmodule

// File: tb/tb_signed_deadband_pwm.sv
module tb_signed_deadband_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int DB  = 82;
  localparam int DIV = 2;
  localparam int PER = 2047 - DB;

  logic clk = 0, en = 0, coarse_mode = 0;
  logic [11:0] code = 12'h000;
  logic drive_pos, drive_neg, in_band;

  signed_deadband_pwm #(.CODE_W(12), .DEADBAND(DB), .SLOW_DIV(DIV), .COARSE_BITS(8)) dut (
    .clk(clk), .en(en), .coarse_mode(coarse_mode), .code(code),
    .drive_pos(drive_pos), .drive_neg(drive_neg), .in_band(in_band));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int m_cnt = 0, m_pre = 0, m_duty = 0;
  bit m_neg = 0, m_band = 0, m_slow = 0, m_wrapped = 0, started = 0;

  task automatic load_model();
    int e, mg;
    e = coarse_mode ? int'(code & 12'hFF0) : int'(code);
    if (e >= 2048) e = e - 4096;
    mg = (e < 0) ? -e : e;
    m_neg  = (e < 0);
    m_band = (mg <= DB);
    m_duty = m_band ? 0 : ((mg - DB > PER) ? PER : mg - DB);
    m_slow = coarse_mode;
  endtask

  always @(posedge clk) begin
    bit tick;
    cycles++;
    started = 1;
    m_wrapped = 0;
    if (!en) begin
      m_cnt = 0; m_pre = 0; load_model();
    end else begin
      tick = !m_slow || (m_pre == DIV - 1);
      if (m_slow) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      else m_pre = 0;
      if (tick) begin
        if (m_cnt == PER - 1) begin
          m_cnt = 0; load_model(); m_wrapped = 1;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) if (started) begin
    bit ep, en_n;
    string tag;
    ep   = en && !m_neg && (m_cnt < m_duty);
    en_n = en &&  m_neg && (m_cnt < m_duty);
    if (!en) tag = "R7";
    else if (m_band) tag = "R3";
    else if (m_slow) tag = "R5";
    else tag = "R2";
    checks++;
    if ({drive_pos, drive_neg, in_band} !== {ep, en_n, m_band}) begin
      fails++;
      $display("FAIL %s pos/neg/band actual %b%b%b expected %b%b%b at cycle %0d",
               tag, drive_pos, drive_neg, in_band, ep, en_n, m_band, cycles);
    end
  end

  task automatic measure(input string tag, input int exp_pos, input int exp_neg);
    int np = 0, nn = 0, len;
    @(negedge clk);
    while (!m_wrapped) @(negedge clk);
    len = m_slow ? PER * DIV : PER;
    for (int i = 0; i < len; i++) begin
      np += drive_pos; nn += drive_neg;
      @(negedge clk);
    end
    checks++;
    if (np != exp_pos || nn != exp_neg) begin
      fails++;
      $display("FAIL %s high counts actual pos=%0d neg=%0d expected pos=%0d neg=%0d",
               tag, np, nn, exp_pos, exp_neg);
    end
  endtask

  task automatic set_code(input logic [11:0] c, input logic m);
    @(negedge clk); #1; code = c; coarse_mode = m;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (drive_pos || drive_neg) begin
      fails++;
      $display("FAIL R7 reset outputs actual %b%b expected 00", drive_pos, drive_neg);
    end
    set_code(12'h100, 0); #1; en = 1;
    measure("R2 positive 0x100", 174, 0);
    set_code(12'hF00, 0); measure("R1 negative 0xF00", 0, 174);
    set_code(12'h052, 0); measure("R3 band edge +0x52", 0, 0);
    set_code(12'h053, 0); measure("R2 just outside +0x53", 1, 0);
    set_code(12'hFAE, 0); measure("R3 band edge -0x52", 0, 0);
    set_code(12'hFAD, 0); measure("R2 just outside -0x53", 0, 1);
    set_code(12'h7FF, 0); measure("R4 full scale 0x7FF", PER, 0);
    set_code(12'h800, 0); measure("R4 full scale 0x800", 0, PER);
    set_code(12'h05F, 0); measure("R8 fine 0x05F", 13, 0);
    set_code(12'h123, 1); measure("R5 coarse 0x123", 206 * DIV, 0);
    set_code(12'h05F, 1); measure("R5 coarse 0x05F in band", 0, 0);
    set_code(12'h300, 0); measure("R6 back to fine 0x300", 768 - DB, 0);
    repeat (100) @(negedge clk);
    #1 code = 12'hC00;
    repeat (300) @(negedge clk);
    #1 code = 12'h300;
    measure("R6 mid-period write ignored", 768 - DB, 0);
    repeat (200) @(negedge clk);
    #1 en = 0;
    repeat (10) @(negedge clk);
    #1 code = 12'hE00; en = 1;
    measure("R7 restart after disable", 0, 512 - DB);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R2 watchdog actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule